// File: doc/BRIEF.md
# Decode-Stage Branch Hazard Unit

This block decides when a five-stage in-order integer pipeline must stall, and when it must redirect fetch, for conditional branches that compare two registers in the decode stage. It decodes the instruction word held in IF/ID. It compares the instruction's two source registers against the destinations held in the EX, MEM and WB pipeline registers. From that it drives a hold for the PC and IF/ID, a bubble request for ID/EX, and a flush of IF/ID together with the branch target when the branch is taken.

The block holds a small register file. A write-back in a cycle is visible to a decode read in that same cycle, so a result in WB never causes a stall and needs no forwarding path. A producer in EX always stalls a dependent branch. A load in MEM also stalls it, because its data does not exist yet. An ALU result in MEM is forwarded straight into the decode comparator. With these rules, a load followed at once by a dependent branch costs two bubbles. One independent instruction between them cuts this to one bubble, and an ALU producer costs one bubble.

Top module: `brh_unit`

## Requirements
- R1: Bits [31:26] of the instruction word are the opcode. 6'b000100 is branch-if-equal and 6'b000101 is branch-if-not-equal. The first source register is bits [25:21], the second is bits [20:16], and the signed offset is bits [15:0]. Any other opcode never raises hold, bubble or flush.
- R2: `br_target` equals `id_pc` + 4 + (sign-extended offset shifted left by two). For example, word 0x1067FFE2 at PC 0x1D0 gives 0x15C.
- R3: `ifid_flush` is high exactly when a branch is in decode, no stall is raised, and its condition holds: the operands are equal for branch-if-equal, or differ for branch-if-not-equal.
- R4: A branch whose source register is written by the instruction in EX (write-enable set, destination non-zero) stalls. A load followed at once by such a branch therefore sees two stall cycles.
- R5: A branch whose source register is the destination of a load in MEM stalls. When one independent instruction separates the load from the branch, there is exactly one stall cycle.
- R6: A non-load producer in MEM does not stall a dependent branch. Its `mem_val` is used as the compared operand and appears on `id_a`/`id_b`.
- R7: A write in WB is returned to a same-cycle decode read of that register without a stall. The value is also kept for later reads.
- R8: While stalled, `pc_hold` and `idex_bubble` are both high and `ifid_flush` is low.
- R9: Register 0 creates no dependency, always reads as zero, and ignores writes.
- R10: Synchronous active-high reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_pc | input | 32 | PC of the instruction in decode |
| id_instr | input | 32 | Instruction word in IF/ID |
| ex_rd | input | 5 | Destination register in ID/EX |
| ex_we | input | 1 | Register write enable in ID/EX |
| mem_rd | input | 5 | Destination register in EX/MEM |
| mem_we | input | 1 | Register write enable in EX/MEM |
| mem_ld | input | 1 | EX/MEM instruction is a load |
| mem_val | input | 32 | ALU result held in EX/MEM |
| wb_rd | input | 5 | Destination register in MEM/WB |
| wb_we | input | 1 | Register write enable in MEM/WB |
| wb_data | input | 32 | Write-back data |
| pc_hold | output | 1 | Hold PC and IF/ID this cycle |
| idex_bubble | output | 1 | Load an all-zero control word into ID/EX |
| ifid_flush | output | 1 | Taken branch: squash IF/ID and load the target |
| br_target | output | 32 | Computed branch target |
| id_a | output | 32 | First compared operand after forwarding |
| id_b | output | 32 | Second compared operand after forwarding |

## Verification
Directed sequences replay the pipeline shapes that matter, each with its own stall count:
- a load right before a dependent branch (two stalls);
- a load with one gap instruction (one stall);
- an ALU producer (one stall, then a forwarded value);
- a write-back in the decode cycle (no stall, same-cycle value);
- writes to and reads of register 0.

The known encoding 0x1067FFE2 pins the target arithmetic, including a negative offset. Random cycles draw register numbers from a narrow range, so hazards in EX, MEM and WB collide with each other and with equal or unequal operands. This separates priority mistakes between MEM forwarding and WB write-through, and a wrong stall source from a wrong flush condition.

// File: rtl/brh_pkg.sv
package brh_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned NREG   = 1 << REG_AW;
  localparam logic [5:0]  OP_BEQ = 6'b000100;
  localparam logic [5:0]  OP_BNE = 6'b000101;

  typedef struct packed {
    logic [5:0]        op;
    logic [REG_AW-1:0] src_a;
    logic [REG_AW-1:0] src_b;
    logic [15:0]       off;
  } br_fields_t;
endpackage

// File: rtl/brh_regfile.sv
module brh_regfile #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned NP   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           wa,
  input  logic [XLEN-1:0]         wd,
  input  logic [NP-1:0][AW-1:0]   ra,
  output logic [NP-1:0][XLEN-1:0] rdat
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [XLEN-1:0] mem [DEPTH];
  logic            wr_ok;

  assign wr_ok = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wa] <= wd;
    end
  end

  // first-half write, second-half read: same-cycle value passes through
  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdat[p] = (wr_ok && (wa == ra[p])) ? wd : mem[ra[p]];
  end

  // R9: register 0 stays zero whatever is written
  a_r9_zero_kept: assert property (@(posedge clk) disable iff (rst)
    mem[0] == '0);

  // R7: an accepted write is held for later reads
  a_r7_commit: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> mem[$past(wa)] == $past(wd));
endmodule

// File: rtl/brh_stall_det.sv
module brh_stall_det #(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_br,
  input  logic [AW-1:0] src_a,
  input  logic [AW-1:0] src_b,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_ld,
  output logic          stall
);
  logic ex_hit, mem_ld_hit;

  always_comb begin
    ex_hit     = ex_we && (ex_rd != '0) &&
                 ((ex_rd == src_a) || (ex_rd == src_b));
    mem_ld_hit = mem_we && mem_ld && (mem_rd != '0) &&
                 ((mem_rd == src_a) || (mem_rd == src_b));
    stall      = is_br && (ex_hit || mem_ld_hit);
  end

  // R8/R1: a stall is only ever raised for a branch in decode
  a_r8_stall_needs_branch: assert property (@(posedge clk) disable iff (rst)
    stall |-> is_br);
endmodule

// File: rtl/brh_opnd_fwd.sv
module brh_opnd_fwd #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5
) (
  input  logic [AW-1:0]   src,
  input  logic [XLEN-1:0] rf_val,
  input  logic [AW-1:0]   mem_rd,
  input  logic            mem_we,
  input  logic            mem_ld,
  input  logic [XLEN-1:0] mem_val,
  output logic [XLEN-1:0] val
);
  always_comb begin
    if (src == '0)
      val = '0;
    else if (mem_we && !mem_ld && (mem_rd == src))
      val = mem_val;
    else
      val = rf_val;
  end
endmodule

// File: rtl/brh_unit.sv
module brh_unit
  import brh_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   id_pc,
  input  logic [31:0]       id_instr,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_ld,
  input  logic [XLEN-1:0]   mem_val,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic [XLEN-1:0]   wb_data,
  output logic              pc_hold,
  output logic              idex_bubble,
  output logic              ifid_flush,
  output logic [XLEN-1:0]   br_target,
  output logic [XLEN-1:0]   id_a,
  output logic [XLEN-1:0]   id_b
);
  localparam int unsigned NSRC = 2;
  localparam int unsigned EXTW = XLEN - 18;

  br_fields_t                   fld;
  logic                         is_beq, is_bne, is_br, stall, cond;
  logic [NSRC-1:0][REG_AW-1:0]  src;
  logic [NSRC-1:0][XLEN-1:0]    rf_q, opv;

  assign fld    = br_fields_t'(id_instr);
  assign is_beq = (fld.op == OP_BEQ);
  assign is_bne = (fld.op == OP_BNE);
  assign is_br  = is_beq || is_bne;
  assign src[0] = fld.src_a;
  assign src[1] = fld.src_b;

  brh_regfile #(.XLEN(XLEN), .AW(REG_AW), .NP(NSRC)) u_rf (
    .clk(clk), .rst(rst), .we(wb_we), .wa(wb_rd), .wd(wb_data),
    .ra(src), .rdat(rf_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_fwd
    brh_opnd_fwd #(.XLEN(XLEN), .AW(REG_AW)) u_fwd (
      .src(src[s]), .rf_val(rf_q[s]), .mem_rd(mem_rd), .mem_we(mem_we),
      .mem_ld(mem_ld), .mem_val(mem_val), .val(opv[s])
    );
  end

  brh_stall_det #(.AW(REG_AW)) u_stall (
    .clk(clk), .rst(rst), .is_br(is_br), .src_a(src[0]), .src_b(src[1]),
    .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_ld(mem_ld), .stall(stall)
  );

  always_comb begin
    cond        = is_beq ? (opv[0] == opv[1]) : (opv[0] != opv[1]);
    pc_hold     = stall;
    idex_bubble = stall;
    ifid_flush  = is_br && !stall && cond;
    br_target   = id_pc + XLEN'(4) + {{EXTW{fld.off[15]}}, fld.off, 2'b00};
    id_a        = opv[0];
    id_b        = opv[1];
  end

  // R3/R8: a redirect never coincides with a stall
  a_r3_no_flush_in_stall: assert property (@(posedge clk) disable iff (rst)
    ifid_flush |-> !pc_hold);

  // R6: an ALU result in MEM feeds the comparator when EX does not collide
  a_r6_mem_forward: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ld && mem_rd != '0 && mem_rd == fld.src_a &&
     !(ex_we && ex_rd == fld.src_a)) |-> id_a == mem_val);

  // R5: a load in MEM feeding a branch always holds the front end
  a_r5_load_in_mem: assert property (@(posedge clk) disable iff (rst)
    (is_br && mem_we && mem_ld && mem_rd != '0 && mem_rd == fld.src_b)
      |-> (pc_hold && idex_bubble));
endmodule

// File: tb/brh_unit_bench.sv
module brh_unit_bench;
  localparam int CLK_P = 10;

  logic        clk = 0, rst = 1;
  logic [31:0] id_pc, id_instr, mem_val, wb_data;
  logic [4:0]  ex_rd, mem_rd, wb_rd;
  logic        ex_we, mem_we, mem_ld, wb_we;
  logic        pc_hold, idex_bubble, ifid_flush;
  logic [31:0] br_target, id_a, id_b;

  int total = 0, bad = 0, holds = 0;
  logic [31:0] rf [32];
  logic        stall_seen;

  always #(CLK_P/2) clk = ~clk;

  brh_unit u_brh_unit (
    .clk(clk), .rst(rst), .id_pc(id_pc), .id_instr(id_instr),
    .ex_rd(ex_rd), .ex_we(ex_we), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_ld(mem_ld), .mem_val(mem_val), .wb_rd(wb_rd), .wb_we(wb_we),
    .wb_data(wb_data), .pc_hold(pc_hold), .idex_bubble(idex_bubble),
    .ifid_flush(ifid_flush), .br_target(br_target), .id_a(id_a), .id_b(id_b)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] opval(input logic [4:0] r);
    if (r == 0) return 0;
    if (mem_we && !mem_ld && mem_rd == r) return mem_val;
    if (wb_we && wb_rd == r) return wb_data;
    return rf[r];
  endfunction

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] a,
                                     input logic [4:0] b, input logic [15:0] o);
    return {op, a, b, o};
  endfunction

  task automatic idle_stages();
    ex_rd = 0; ex_we = 0; mem_rd = 0; mem_we = 0; mem_ld = 0; mem_val = 0;
    wb_rd = 0; wb_we = 0; wb_data = 0;
  endtask

  // inputs are set at a falling edge; compare against the reference, then advance
  task automatic step(input string tag);
    logic [5:0]  op;
    logic [4:0]  a, b;
    logic        br, st, tk, eh, mh;
    logic [31:0] va, vb, tgt;
    #1;
    op = id_instr[31:26]; a = id_instr[25:21]; b = id_instr[20:16];
    br = (op == 6'b000100) || (op == 6'b000101);
    eh = ex_we && ex_rd != 0 && (ex_rd == a || ex_rd == b);
    mh = mem_we && mem_ld && mem_rd != 0 && (mem_rd == a || mem_rd == b);
    st = br && (eh || mh);
    va = opval(a); vb = opval(b);
    tk = br && !st && ((op == 6'b000100) ? (va == vb) : (va != vb));
    tgt = id_pc + 32'd4 + {{14{id_instr[15]}}, id_instr[15:0], 2'b00};
    stall_seen = pc_hold;
    chk(pc_hold == st, {tag, " R4/R5 hold"}, 32'(pc_hold), 32'(st));
    chk(idex_bubble == st, {tag, " R8 bubble"}, 32'(idex_bubble), 32'(st));
    chk(ifid_flush == tk, {tag, " R3 flush"}, 32'(ifid_flush), 32'(tk));
    chk(br_target == tgt, {tag, " R2 target"}, br_target, tgt);
    if (!st) begin
      chk(id_a == va, {tag, " R6/R7 opnd a"}, id_a, va);
      chk(id_b == vb, {tag, " R6/R7 opnd b"}, id_b, vb);
    end
    @(posedge clk);
    if (wb_we && wb_rd != 0) rf[wb_rd] = wb_data;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 32; i++) rf[i] = 0;
    idle_stages(); id_pc = 0; id_instr = 0;
    repeat (2) @(posedge clk);
    // write garbage during reset; reset must win (R10)
    wb_we = 1; wb_rd = 4; wb_data = 32'hDEAD;
    @(negedge clk); rst = 0; idle_stages();

    // R10: after reset registers read zero -> beq r5,r6 taken
    id_pc = 32'h100; id_instr = mk(6'b000100, 5, 6, 16'd3);
    #1;
    chk(id_a == 0 && id_b == 0, "R10 reset regs zero", id_a, 0);
    chk(ifid_flush == 1, "R10 R3 equal zeros taken", 32'(ifid_flush), 1);
    step("reset");
    id_instr = mk(6'b000100, 4, 0, 16'd0); #1;
    chk(id_a == 0, "R10 write under reset dropped", id_a, 0);
    step("reset2");

    // R2: known encoding
    id_pc = 32'h1D0; id_instr = 32'h1067FFE2; #1;
    chk(br_target == 32'h15C, "R2 0x1067FFE2 target", br_target, 32'h15C);
    step("enc");

    // R4: load then dependent branch -> two stalls, then WB write-through (R7)
    holds = 0;
    id_instr = mk(6'b000100, 1, 2, 16'd8);
    idle_stages(); ex_rd = 1; ex_we = 1; step("ld+0 a"); holds += stall_seen;
    idle_stages(); mem_rd = 1; mem_we = 1; mem_ld = 1; step("ld+0 b"); holds += stall_seen;
    idle_stages(); wb_rd = 1; wb_we = 1; wb_data = 32'h55;
    #1;
    chk(id_a == 32'h55, "R7 same-cycle WB value", id_a, 32'h55);
    chk(pc_hold == 0, "R7 WB no stall", 32'(pc_hold), 0);
    step("ld+0 c"); holds += stall_seen;
    chk(holds == 2, "R4 load-branch two bubbles", holds, 2);
    idle_stages(); id_instr = mk(6'b000101, 1, 0, 16'd0); #1;
    chk(id_a == 32'h55, "R7 value kept", id_a, 32'h55);
    step("kept");

    // R5: load, one independent instr, branch -> one stall
    holds = 0;
    id_instr = mk(6'b000101, 3, 1, 16'hFFFF);
    idle_stages(); mem_rd = 3; mem_we = 1; mem_ld = 1; ex_rd = 9; ex_we = 1;
    step("ld+1 a"); holds += stall_seen;
    idle_stages(); wb_rd = 3; wb_we = 1; wb_data = 32'h55; mem_rd = 9; mem_we = 1;
    mem_val = 32'h1;
    step("ld+1 b"); holds += stall_seen;
    chk(holds == 1, "R5 load-gap-branch one bubble", holds, 1);

    // R6: ALU producer -> one stall, then forwarded from MEM
    holds = 0;
    id_instr = mk(6'b000100, 1, 2, 16'd4);
    idle_stages(); ex_rd = 2; ex_we = 1; step("alu a"); holds += stall_seen;
    idle_stages(); mem_rd = 2; mem_we = 1; mem_val = 32'h55;
    wb_rd = 2; wb_we = 1; wb_data = 32'h77; #1;
    chk(id_b == 32'h55, "R6 MEM result beats WB", id_b, 32'h55);
    chk(ifid_flush == 1, "R6 R3 forwarded equal taken", 32'(ifid_flush), 1);
    step("alu b"); holds += stall_seen;
    chk(holds == 1, "R6 ALU-branch one bubble", holds, 1);

    // R9: register 0
    idle_stages(); id_instr = mk(6'b000100, 0, 0, 16'd1);
    ex_rd = 0; ex_we = 1; mem_rd = 0; mem_we = 1; mem_ld = 1;
    wb_rd = 0; wb_we = 1; wb_data = 32'h123; #1;
    chk(pc_hold == 0, "R9 r0 no dependency", 32'(pc_hold), 0);
    chk(id_a == 0, "R9 r0 reads zero under write", id_a, 0);
    step("r0 a");
    idle_stages(); #1;
    chk(id_a == 0, "R9 r0 write ignored", id_a, 0);
    step("r0 b");

    // R1: non-branch opcode with EX hazard
    idle_stages(); id_instr = mk(6'b100011, 1, 2, 16'd0); ex_rd = 1; ex_we = 1; #1;
    chk(pc_hold == 0 && ifid_flush == 0, "R1 non-branch quiet", 32'(pc_hold), 0);
    step("nonbr");

    // R8: stall blocks flush even when operands would be equal
    idle_stages(); id_instr = mk(6'b000100, 7, 7, 16'd0); ex_rd = 7; ex_we = 1; #1;
    chk(pc_hold && idex_bubble && !ifid_flush, "R8 stall signals", 32'(ifid_flush), 0);
    step("stall");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [5:0] op;
      case ($urandom_range(0, 3))
        0, 1: op = 6'b000100;
        2: op = 6'b000101;
        default: op = 6'b001000;
      endcase
      id_pc = $urandom & 32'hFFFC;
      id_instr = mk(op, 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                    16'($urandom));
      ex_rd = 5'($urandom_range(0, 7)); ex_we = 1'($urandom);
      mem_rd = 5'($urandom_range(0, 7)); mem_we = 1'($urandom);
      mem_ld = 1'($urandom); mem_val = $urandom_range(0, 3);
      wb_rd = 5'($urandom_range(0, 7)); wb_we = 1'($urandom);
      wb_data = $urandom_range(0, 3);
      step("random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule